// File: doc/BRIEF.md
# Region-Decoded Memory Router with Aligner

The block sits between a CPU's load/store/fetch port and a set of on-chip memories. It uses the top address byte to pick a region: a tightly coupled RAM, a main RAM, a work-RAM window, or a boot ROM. It then forms byte-lane enables for narrow writes. For reads, it rotates or extracts the returned word according to the low address bits.

The work-RAM window is split at runtime by a shared-size input:
- Addresses below a fixed private base go to a shared RAM, wrapped to the configured size.
- Everything else goes to a private RAM.
- A shared size of zero sends the whole window to private RAM.

The tightly coupled RAM answers only inside a window of 512 bytes shifted left by a programmable virtual-size input.

Every access gets a registered response one cycle after the request. The response carries a wait count, and an error pulse for any access that lands outside a valid region. Instruction fetches from such places return a fixed undefined-instruction pattern.

Top module: `mem_router`

## Requirements
- R1: Region is chosen by `addr_i[31:24]`. The defaults are: 0x00 and 0x01 for the tightly coupled RAM, 0x02 for main RAM, 0x03 for the work window, and 0xFF for the ROM. Every other code is unmapped. Main RAM (1 KiB) wraps on its size.
- R2: A word read (`size_i`=2) returns the aligned word rotated right by 8×`addr_i[1:0]`.
- R3: A halfword read (`size_i`=1) takes the halfword selected by `addr_i[1]`, zero-extends it, and rotates it right by 8×`addr_i[0]`.
- R4: A byte read (`size_i`=0) returns the addressed byte zero-extended to 32 bits.
- R5: Writes use byte enables. A byte write changes only lane `addr_i[1:0]`, a halfword write only lanes selected by `addr_i[1]`, and a word write all four lanes at the aligned address.
- R6: In the work window, addresses at or above 0x0380_0000 select private RAM (1 KiB), indexed by the address masked to its size.
- R7: Work-window addresses below the private base select shared RAM, indexed by the address masked with `shared_size_i`−1. A `shared_size_i` of 0 sends those accesses to private RAM.
- R8: A tightly coupled RAM access is valid only if `addr_i` < 512<<`tcm_vsize_i`. A valid access indexes the 512-byte RAM with the address masked to 512. An access outside the window is invalid, and its write is dropped.
- R9: A read of an unmapped region returns 0 with `err_o`. A write to one is dropped with `err_o`.
- R10: An instruction fetch (`fetch_i`=1) from any invalid place, including the ROM with `rom_present_i`=0, returns 0xE710B710 with `err_o`.
- R11: Each request is answered exactly one cycle later. `wait_o` is 2 for loads and fetches and 1 for stores. `rvalid_o` is high only for loads and fetches.
- R12: ROM word i reads as {0xC0, i[7:0], ~i[7:0], 0x3C}. The ROM is read-only: a write to it is dropped and flagged. A data read with the ROM absent returns 0 with `err_o`.
- R13: `err_o` is a one-cycle pulse per invalid access. A cycle without a request is followed by `err_o`, `rvalid_o` and `wait_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = store |
| fetch_i | input | 1 | 1 = instruction fetch (word read) |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data, low-aligned |
| shared_size_i | input | 11 | Shared work-RAM size in bytes (power of two or 0) |
| tcm_vsize_i | input | 5 | Tightly coupled RAM virtual-size shift |
| rom_present_i | input | 1 | Boot ROM fitted |
| rdata_o | output | 32 | Aligned read data |
| rvalid_o | output | 1 | Read response valid |
| wait_o | output | 2 | Wait cycles charged for the access |
| err_o | output | 1 | Invalid-access pulse |

## Verification
A single known word is read at all four byte offsets with each of the three sizes. This separates rotation from extraction and shows the halfword lane choice from `addr_i[1]`.

Byte and halfword stores into that word show that only the enabled lanes change. The same offset is written through the shared and private paths under different `shared_size_i` values, which shows whether the split and its zero case divert correctly.

Tightly coupled RAM writes just inside and just outside the window, followed by an aliased read, show whether the window gate drops writes. Unmapped, ROM-absent and ROM-write accesses, each issued as both read and fetch, separate the zero-return, pattern-return and error paths.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_ROM, SEL_MAIN, SEL_SHARED, SEL_PRIV, SEL_TCM
  } mr_sel_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [31:0] UNDEF_PAT = 32'hE710_B710;

  function automatic logic [31:0] rom_word(input logic [7:0] i);
    return {8'hC0, i, ~i, 8'h3C};
  endfunction
endpackage

// File: rtl/mr_decode.sv
module mr_decode import mr_pkg::*; #(
  parameter logic [7:0]  REG_TCM0   = 8'h00,
  parameter logic [7:0]  REG_TCM1   = 8'h01,
  parameter logic [7:0]  REG_MAIN   = 8'h02,
  parameter logic [7:0]  REG_WORK   = 8'h03,
  parameter logic [7:0]  REG_ROM    = 8'hFF,
  parameter logic [31:0] PRIV_BASE  = 32'h0380_0000,
  parameter int unsigned MAIN_BYTES = 1024,
  parameter int unsigned SHR_BYTES  = 1024,
  parameter int unsigned PRV_BYTES  = 1024,
  parameter int unsigned TCM_BYTES  = 512,
  parameter int unsigned ROM_BYTES  = 256,
  parameter int unsigned SSW        = 11,
  parameter int unsigned IW         = 8
) (
  input  logic [31:0]   addr_i,
  input  logic          we_i,
  input  logic [SSW-1:0] shared_size_i,
  input  logic [4:0]    tcm_vsize_i,
  input  logic          rom_present_i,
  output mr_sel_e       sel_o,
  output logic [IW-1:0] widx_o
);
  logic [7:0]  region;
  logic [31:0] off;
  logic [31:0] shr_mask;
  logic [63:0] tcm_win;

  assign region   = addr_i[31:24];
  assign shr_mask = 32'(shared_size_i) - 32'd1;
  assign tcm_win  = 64'd512 << tcm_vsize_i;

  always_comb begin
    sel_o = SEL_NONE;
    off   = '0;
    if (region == REG_TCM0 || region == REG_TCM1) begin
      if ({32'd0, addr_i} < tcm_win) begin
        sel_o = SEL_TCM;
        off   = addr_i & (TCM_BYTES - 1);
      end
    end else if (region == REG_MAIN) begin
      sel_o = SEL_MAIN;
      off   = addr_i & (MAIN_BYTES - 1);
    end else if (region == REG_WORK) begin
      if (addr_i >= PRIV_BASE || shared_size_i == '0) begin
        sel_o = SEL_PRIV;
        off   = addr_i & (PRV_BYTES - 1);
      end else begin
        sel_o = SEL_SHARED;
        off   = addr_i & shr_mask & (SHR_BYTES - 1);
      end
    end else if (region == REG_ROM) begin
      if (rom_present_i && !we_i) begin
        sel_o = SEL_ROM;
        off   = addr_i & (ROM_BYTES - 1);
      end
    end
  end

  assign widx_o = off[IW+1:2];
endmodule

// File: rtl/mr_wlane.sv
module mr_wlane import mr_pkg::*; (
  input  logic [1:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [3:0]  be_o,
  output logic [31:0] data_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_o   = 4'b0001 << off_i;
        data_o = {4{wdata_i[7:0]}};
      end
      SZ_HALF: begin
        be_o   = off_i[1] ? 4'b1100 : 4'b0011;
        data_o = {2{wdata_i[15:0]}};
      end
      default: begin
        be_o   = 4'b1111;
        data_o = wdata_i;
      end
    endcase
  end
endmodule

// File: rtl/mr_ralign.sv
module mr_ralign import mr_pkg::*; (
  input  logic [1:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] word_i,
  output logic [31:0] data_o
);
  logic [63:0] dbl;
  logic [15:0] half;
  logic [63:0] hdbl;

  assign dbl  = {word_i, word_i};
  assign half = off_i[1] ? word_i[31:16] : word_i[15:0];
  assign hdbl = {16'd0, half, 16'd0, half};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {24'd0, word_i[8*off_i +: 8]};
      SZ_HALF: data_o = hdbl[8*off_i[0] +: 32];
      default: data_o = dbl[8*off_i +: 32];
    endcase
  end
endmodule

// File: rtl/mr_ram.sv
module mr_ram #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [3:0]    be_i,
  input  logic [AW-1:0] idx_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (we_i && be_i[l]) mem[idx_i] <= wdata_i[8*l +: 8];
        rdata_o[8*l +: 8] <= mem[idx_i];
      end
    end
  end
endmodule

// File: rtl/mem_router.sv
module mem_router import mr_pkg::*; #(
  parameter logic [7:0]  REG_TCM0   = 8'h00,
  parameter logic [7:0]  REG_TCM1   = 8'h01,
  parameter logic [7:0]  REG_MAIN   = 8'h02,
  parameter logic [7:0]  REG_WORK   = 8'h03,
  parameter logic [7:0]  REG_ROM    = 8'hFF,
  parameter logic [31:0] PRIV_BASE  = 32'h0380_0000,
  parameter int unsigned MAIN_WORDS = 256,
  parameter int unsigned SHR_WORDS  = 256,
  parameter int unsigned PRV_WORDS  = 256,
  parameter int unsigned TCM_WORDS  = 128,
  parameter int unsigned ROM_WORDS  = 64,
  localparam int unsigned SSW       = $clog2(SHR_WORDS * 4) + 1,
  localparam int unsigned MAXW      = (MAIN_WORDS > SHR_WORDS ? MAIN_WORDS : SHR_WORDS) > PRV_WORDS ?
                                      (MAIN_WORDS > SHR_WORDS ? MAIN_WORDS : SHR_WORDS) : PRV_WORDS,
  localparam int unsigned IW        = $clog2(MAXW),
  localparam int unsigned MAW       = $clog2(MAIN_WORDS),
  localparam int unsigned SAW       = $clog2(SHR_WORDS),
  localparam int unsigned PAW       = $clog2(PRV_WORDS),
  localparam int unsigned TAW       = $clog2(TCM_WORDS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic           fetch_i,
  input  logic [1:0]     size_i,
  input  logic [31:0]    addr_i,
  input  logic [31:0]    wdata_i,
  input  logic [SSW-1:0] shared_size_i,
  input  logic [4:0]     tcm_vsize_i,
  input  logic           rom_present_i,
  output logic [31:0]    rdata_o,
  output logic           rvalid_o,
  output logic [1:0]     wait_o,
  output logic           err_o
);
  mr_sel_e       sel;
  logic [IW-1:0] widx;
  logic [1:0]    eff_size;
  logic          is_fetch;
  logic [3:0]    be;
  logic [31:0]   wdat;

  assign is_fetch = fetch_i & ~we_i;
  assign eff_size = is_fetch ? SZ_WORD : size_i;

  mr_decode #(
    .REG_TCM0(REG_TCM0), .REG_TCM1(REG_TCM1), .REG_MAIN(REG_MAIN),
    .REG_WORK(REG_WORK), .REG_ROM(REG_ROM), .PRIV_BASE(PRIV_BASE),
    .MAIN_BYTES(MAIN_WORDS * 4), .SHR_BYTES(SHR_WORDS * 4),
    .PRV_BYTES(PRV_WORDS * 4), .TCM_BYTES(TCM_WORDS * 4),
    .ROM_BYTES(ROM_WORDS * 4), .SSW(SSW), .IW(IW)
  ) u_dec (
    .addr_i(addr_i), .we_i(we_i), .shared_size_i(shared_size_i),
    .tcm_vsize_i(tcm_vsize_i), .rom_present_i(rom_present_i),
    .sel_o(sel), .widx_o(widx)
  );

  mr_wlane u_wl (
    .size_i(eff_size), .off_i(addr_i[1:0]), .wdata_i(wdata_i),
    .be_o(be), .data_o(wdat)
  );

  logic [31:0] q_main, q_shr, q_prv, q_tcm;
  logic        wr;
  assign wr = req_i & we_i;

  mr_ram #(.WORDS(MAIN_WORDS)) u_main (
    .clk_i(clk_i), .en_i(req_i && sel == SEL_MAIN), .we_i(wr), .be_i(be),
    .idx_i(widx[MAW-1:0]), .wdata_i(wdat), .rdata_o(q_main));
  mr_ram #(.WORDS(SHR_WORDS)) u_shr (
    .clk_i(clk_i), .en_i(req_i && sel == SEL_SHARED), .we_i(wr), .be_i(be),
    .idx_i(widx[SAW-1:0]), .wdata_i(wdat), .rdata_o(q_shr));
  mr_ram #(.WORDS(PRV_WORDS)) u_prv (
    .clk_i(clk_i), .en_i(req_i && sel == SEL_PRIV), .we_i(wr), .be_i(be),
    .idx_i(widx[PAW-1:0]), .wdata_i(wdat), .rdata_o(q_prv));
  mr_ram #(.WORDS(TCM_WORDS)) u_tcm (
    .clk_i(clk_i), .en_i(req_i && sel == SEL_TCM), .we_i(wr), .be_i(be),
    .idx_i(widx[TAW-1:0]), .wdata_i(wdat), .rdata_o(q_tcm));

  logic [31:0] q_rom;
  always_ff @(posedge clk_i) begin
    if (req_i && sel == SEL_ROM) q_rom <= rom_word(8'(widx));
  end

  // response stage
  logic       vld_q, we_q, fetch_q, bad_q;
  logic [1:0] size_q, off_q;
  mr_sel_e    sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      bad_q   <= 1'b0;
      size_q  <= SZ_BYTE;
      off_q   <= '0;
      sel_q   <= SEL_NONE;
    end else begin
      vld_q   <= req_i;
      we_q    <= we_i;
      fetch_q <= is_fetch;
      bad_q   <= req_i && (sel == SEL_NONE);
      size_q  <= eff_size;
      off_q   <= addr_i[1:0];
      sel_q   <= sel;
    end
  end

  logic [31:0] word_sel, aligned;
  always_comb begin
    unique case (sel_q)
      SEL_MAIN:   word_sel = q_main;
      SEL_SHARED: word_sel = q_shr;
      SEL_PRIV:   word_sel = q_prv;
      SEL_TCM:    word_sel = q_tcm;
      SEL_ROM:    word_sel = q_rom;
      default:    word_sel = '0;
    endcase
  end

  mr_ralign u_ra (
    .size_i(size_q), .off_i(off_q), .word_i(word_sel), .data_o(aligned)
  );

  assign rvalid_o = vld_q & ~we_q;
  assign err_o    = vld_q & bad_q;
  assign wait_o   = !vld_q ? 2'd0 : (we_q ? 2'd1 : 2'd2);

  always_comb begin
    if (!rvalid_o)   rdata_o = '0;
    else if (bad_q)  rdata_o = fetch_q ? UNDEF_PAT : 32'd0;
    else             rdata_o = aligned;
  end
endmodule

// File: rtl/mem_router_chk.sv
module mem_router_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        fetch_i,
  input logic [1:0]  size_i,
  input logic [31:0] rdata_o,
  input logic        rvalid_o,
  input logic [1:0]  wait_o,
  input logic        err_o
);
  p_load_wait_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> (rvalid_o && wait_o == 2'd2));

  p_store_wait_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (!rvalid_o && wait_o == 2'd1));

  p_idle_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!err_o && !rvalid_o && wait_o == 2'd0));

  p_bad_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !fetch_i) |=> (err_o -> rdata_o == 32'd0));

  p_bad_fetch_pat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && fetch_i) |=> (err_o -> rdata_o == 32'hE710_B710));

  p_byte_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !fetch_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'd0));

  p_half_ext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !fetch_i && size_i == 2'd1) |=> ($countones(rdata_o) <= 16));
endmodule

bind mem_router mem_router_chk u_chk (.*);

// File: tb/sim_mem_router.sv
module sim_mem_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, fetch = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] addr = '0, wdata = '0;
  logic [10:0] shsz = '0;
  logic [4:0]  vsz = '0;
  logic        romp = 1'b1;
  logic [31:0] rdata;
  logic        rvalid, err;
  logic [1:0]  waitc;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mem_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .fetch_i(fetch),
    .size_i(size), .addr_i(addr), .wdata_i(wdata), .shared_size_i(shsz),
    .tcm_vsize_i(vsz), .rom_present_i(romp), .rdata_o(rdata),
    .rvalid_o(rvalid), .wait_o(waitc), .err_o(err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic f, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic e);
    @(negedge clk);
    req = 1'b1; we = w; fetch = f; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; fetch = 1'b0;
    rd = rdata; e = err;
    check("R11 wait", {30'd0, waitc}, w ? 32'd1 : 32'd2);
    check("R11 rvalid", {31'd0, rvalid}, {31'd0, ~w});
  endtask

  function automatic logic [31:0] romw(input int i);
    return {8'hC0, 8'(i), ~8'(i), 8'h3C};
  endfunction

  logic [31:0] rd;
  logic        e;

  task automatic t_reset;
    check("R13 reset err", {31'd0, err}, 0);
    check("R13 reset wait", {30'd0, waitc}, 0);
    check("R13 reset rvalid", {31'd0, rvalid}, 0);
  endtask

  task automatic t_align;
    acc(1, 0, 2, 32'h0200_0010, 32'h1122_3344, rd, e);
    check("R9 main write ok", {31'd0, e}, 0);
    acc(0, 0, 2, 32'h0200_0010, 0, rd, e); check("R2 off0", rd, 32'h1122_3344);
    acc(0, 0, 2, 32'h0200_0011, 0, rd, e); check("R2 off1", rd, 32'h4411_2233);
    acc(0, 0, 2, 32'h0200_0012, 0, rd, e); check("R2 off2", rd, 32'h3344_1122);
    acc(0, 0, 2, 32'h0200_0013, 0, rd, e); check("R2 off3", rd, 32'h2233_4411);
    acc(0, 0, 1, 32'h0200_0010, 0, rd, e); check("R3 off0", rd, 32'h0000_3344);
    acc(0, 0, 1, 32'h0200_0011, 0, rd, e); check("R3 off1", rd, 32'h4400_0033);
    acc(0, 0, 1, 32'h0200_0012, 0, rd, e); check("R3 off2", rd, 32'h0000_1122);
    acc(0, 0, 1, 32'h0200_0013, 0, rd, e); check("R3 off3", rd, 32'h2200_0011);
    acc(0, 0, 0, 32'h0200_0010, 0, rd, e); check("R4 byte0", rd, 32'h44);
    acc(0, 0, 0, 32'h0200_0013, 0, rd, e); check("R4 byte3", rd, 32'h11);
    acc(0, 0, 2, 32'h0200_0410, 0, rd, e); check("R1 main wrap", rd, 32'h1122_3344);
  endtask

  task automatic t_lanes;
    acc(1, 0, 0, 32'h0200_0011, 32'hFFFF_FFAB, rd, e);
    acc(0, 0, 2, 32'h0200_0010, 0, rd, e); check("R5 byte write", rd, 32'h1122_AB44);
    acc(1, 0, 1, 32'h0200_0012, 32'hFFFF_BEEF, rd, e);
    acc(0, 0, 2, 32'h0200_0010, 0, rd, e); check("R5 half write", rd, 32'hBEEF_AB44);
  endtask

  task automatic t_work;
    shsz = 11'd0;
    acc(1, 0, 2, 32'h0300_0020, 32'hAAAA_0001, rd, e);
    acc(0, 0, 2, 32'h0380_0020, 0, rd, e); check("R7 zero size to private", rd, 32'hAAAA_0001);
    shsz = 11'd256;
    acc(1, 0, 2, 32'h0300_0020, 32'hBBBB_0002, rd, e);
    acc(0, 0, 2, 32'h0380_0020, 0, rd, e); check("R6 private untouched", rd, 32'hAAAA_0001);
    acc(0, 0, 2, 32'h0300_0120, 0, rd, e); check("R7 shared mask", rd, 32'hBBBB_0002);
    acc(0, 0, 2, 32'h0380_0420, 0, rd, e); check("R6 private wrap", rd, 32'hAAAA_0001);
    shsz = 11'd0;
    acc(0, 0, 2, 32'h0300_0020, 0, rd, e); check("R7 zero again", rd, 32'hAAAA_0001);
  endtask

  task automatic t_tcm;
    vsz = 5'd0;
    acc(1, 0, 2, 32'h0000_01F0, 32'hC0DE_0001, rd, e); check("R8 in window", {31'd0, e}, 0);
    acc(1, 0, 2, 32'h0000_0000, 32'hC0DE_0002, rd, e);
    acc(1, 0, 2, 32'h0000_0200, 32'hDEAD_0003, rd, e); check("R8 out err", {31'd0, e}, 1);
    acc(0, 0, 2, 32'h0000_0000, 0, rd, e); check("R8 write dropped", rd, 32'hC0DE_0002);
    acc(0, 0, 2, 32'h0000_0200, 0, rd, e); check("R8 out read zero", rd, 0);
    vsz = 5'd1;
    acc(0, 0, 2, 32'h0000_03F0, 0, rd, e); check("R8 wider window alias", rd, 32'hC0DE_0001);
    check("R8 wider no err", {31'd0, e}, 0);
    vsz = 5'd0;
  endtask

  task automatic t_unmapped;
    acc(0, 0, 2, 32'h0500_0000, 0, rd, e);
    check("R9 unmapped read", rd, 0); check("R9 unmapped err", {31'd0, e}, 1);
    @(negedge clk); check("R13 err one cycle", {31'd0, err}, 0);
    acc(1, 0, 2, 32'h0500_0000, 32'h1234_5678, rd, e); check("R9 unmapped write err", {31'd0, e}, 1);
    acc(0, 1, 2, 32'h0500_0004, 0, rd, e); check("R10 fetch pattern", rd, 32'hE710_B710);
  endtask

  task automatic t_rom;
    romp = 1'b1;
    acc(0, 0, 2, 32'hFF00_0008, 0, rd, e); check("R12 rom word 2", rd, romw(2));
    check("R12 rom no err", {31'd0, e}, 0);
    acc(1, 0, 2, 32'hFF00_0008, 32'h0, rd, e); check("R12 rom write err", {31'd0, e}, 1);
    acc(0, 1, 2, 32'hFF00_00FC, 0, rd, e); check("R12 rom fetch 63", rd, romw(63));
    acc(0, 0, 2, 32'hFF00_0008, 0, rd, e); check("R12 rom unchanged", rd, romw(2));
    romp = 1'b0;
    acc(0, 1, 2, 32'hFF00_0000, 0, rd, e); check("R10 absent rom fetch", rd, 32'hE710_B710);
    check("R10 absent err", {31'd0, e}, 1);
    acc(0, 0, 2, 32'hFF00_0000, 0, rd, e); check("R12 absent read zero", rd, 0);
    romp = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_align();
    t_lanes();
    t_work();
    t_tcm();
    t_unmapped();
    t_rom();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule